// File: doc/BRIEF.md
# Two-Level Aperture Address Translator

This block maps bus addresses that land inside a fixed graphics aperture window onto physical page addresses. Translation has two levels. The first level is an on-chip directory of 64 entries. Each entry names one 4 KiB table in system memory, and that table holds 1024 32-bit second-level entries. Software loads the directory one entry at a time through a single packed register write. It also picks the aperture size with a coded size field, and it flushes a small translation cache by clearing and then setting an enable bit in a control register.

A client presents one address at a time on a valid/ready handshake. A single-cycle pulse returns either a physical address or a fault. On a cache miss the block issues exactly one read on a simple memory port to fetch the second-level entry. The cache is fully associative, holds four entries, is tagged by aperture page number and refills in round-robin order. Directory presence and the aperture range are checked on every request, so invalidating a directory entry or shrinking the aperture takes effect at once. Remapping a second-level entry needs a cache flush.

Top module: `aperture_xlate`

## Requirements
- R1: After reset every directory entry is absent, the cache is empty, the size field selects 256 MiB and translation is enabled. `req_ready` is 1 and `rsp_valid` and `mem_rd_en` are 0, and any request faults without a memory read.
- R2: A configuration write with `cfg_sel`=0 loads one directory entry. Bits 5:0 pick the entry, bit 8 is the present flag and bits 31:12 give the table's page address. Bits 11:9 and 7:6 have no effect on any translation.
- R3: A directory write with bit 8 clear makes that entry absent. Later requests that map to it fault with no memory read, even if their page is held in the cache.
- R4: The directory entry is chosen by (address − base) bits 27:22 and the table slot by address bits 21:12. A miss issues one single-cycle read at {table page, slot, 2'b00}.
- R5: A fetched entry with bit 0 set gives the response address {entry[31:12], address[11:0]}. An entry with bit 0 clear gives a fault, `rsp_paddr` is 0, and the entry is not cached.
- R6: A configuration write with `cfg_sel`=2'd1 sets the size code. The aperture is 256 MiB shifted right by the number of set bits among code bits 5:3, so 0 gives 256 MiB, 32 gives 128 MiB, 48 gives 64 MiB and 56 gives 32 MiB. An address below the base, or at or past base + size, faults with no memory read.
- R7: A request whose page is cached returns without a memory read. Each fill uses the next of the four ways in rotation, so the fifth distinct fill evicts the first.
- R8: A configuration write with `cfg_sel`=2'd2 sets the enable from bit 7. While the enable is 0, `req_ready` is 0 and no request is accepted. A 0-to-1 change of the enable empties the cache. Writing bit 7 as 1 while it is already 1 leaves the cache intact.
- R9: Only one request is in flight at a time. `rsp_valid` is a one-cycle pulse: two clocks after acceptance on a hit or a fault, three clocks after acceptance on a miss when the memory answers in the cycle after the read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Target register: 0 directory, 1 size code, 2 control |
| cfg_wdata | input | 32 | Configuration write data |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Block can accept a request |
| req_addr | input | 32 | Bus address to translate |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_fault | output | 1 | Response is a fault |
| rsp_paddr | output | 32 | Translated physical address, 0 on fault |
| mem_rd_en | output | 1 | Second-level entry read strobe |
| mem_rd_addr | output | 32 | Byte address of the entry to read |
| mem_rd_valid | input | 1 | Read data is present |
| mem_rd_data | input | 32 | Second-level entry read back |

## Verification
The hardest situation to reach is a stale cache hit meeting a flush. The bench first caches a page, rewrites that page's entry in the memory image, and shows that the old mapping is still returned. It then clears the enable and holds a request against the lowered ready for several cycles. Only after that does it set the enable again, and it expects the held request to miss and pick up the new mapping. Shrinking the aperture while a page at its top is cached covers the case where the range check must win over a cache hit.

// File: rtl/aperture_xlate_pkg.sv
// Shared constants and types for the aperture translator.
// Assumes 32-bit addresses and 4 KiB pages.
package aperture_xlate_pkg;
    localparam int PAGE_SHIFT = 12;
    localparam int L2_IW      = 10;
    localparam int DIR_SHIFT  = PAGE_SHIFT + L2_IW;
    localparam int PPN_W      = 32 - PAGE_SHIFT;

    localparam logic [1:0] SEL_DIR  = 2'd0;
    localparam logic [1:0] SEL_SIZE = 2'd1;
    localparam logic [1:0] SEL_CTRL = 2'd2;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_CHECK = 2'd1,
        ST_WAIT  = 2'd2
    } xl_state_e;
endpackage

// File: rtl/xlate_cfg_regs.sv
// Configuration state: directory, size code and enable bit.
// The directory is read combinationally by index. The flush pulse is
// registered and lines up with the enable rising.
module xlate_cfg_regs
    import aperture_xlate_pkg::*;
#(
    parameter int DIR_ENTRIES = 64,
    parameter int DIR_IW      = $clog2(DIR_ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_sel,
    input  logic [31:0]       cfg_wdata,
    input  logic [DIR_IW-1:0] dir_idx,
    output logic              dir_present,
    output logic [PPN_W-1:0]  dir_ppn,
    output logic [1:0]        size_shift,
    output logic              xl_en,
    output logic              flush
);
    logic [DIR_ENTRIES-1:0] present_q;
    logic [PPN_W-1:0]       ppn_q [DIR_ENTRIES];
    logic [2:0]             size_q;
    logic [DIR_IW-1:0]      wr_idx;
    logic                   dir_wr, size_wr, ctrl_wr;
    logic                   unused_cfg;

    assign wr_idx     = cfg_wdata[DIR_IW-1:0];
    assign dir_wr     = cfg_we && (cfg_sel == SEL_DIR);
    assign size_wr    = cfg_we && (cfg_sel == SEL_SIZE);
    assign ctrl_wr    = cfg_we && (cfg_sel == SEL_CTRL);
    assign unused_cfg = ^{cfg_wdata[11:9], cfg_wdata[6]};

    // Present flags: all cleared at reset, one entry updated per write
    always_ff @(posedge clk) begin
        if (!rst_n)      present_q         <= '0;
        else if (dir_wr) present_q[wr_idx] <= cfg_wdata[8];
    end

    // Table page addresses need no reset: their use is gated by the present flag
    always_ff @(posedge clk) begin
        if (dir_wr) ppn_q[wr_idx] <= cfg_wdata[31:PAGE_SHIFT];
    end

    // Size code: only bits 5:3 matter
    always_ff @(posedge clk) begin
        if (!rst_n)       size_q <= '0;
        else if (size_wr) size_q <= cfg_wdata[5:3];
    end

    // Enable bit and the flush pulse on its rising change
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            xl_en <= 1'b1;
            flush <= 1'b0;
        end else begin
            flush <= ctrl_wr && cfg_wdata[7] && !xl_en;
            if (ctrl_wr) xl_en <= cfg_wdata[7];
        end
    end

    assign dir_present = present_q[dir_idx];
    assign dir_ppn     = ppn_q[dir_idx];
    assign size_shift  = {1'b0, size_q[2]} + {1'b0, size_q[1]} + {1'b0, size_q[0]};

    // R8
    flush_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |-> (xl_en && !$past(xl_en)));
    // R3
    dir_inval_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dir_wr && !cfg_wdata[8]) |=> !present_q[$past(wr_idx)]);
endmodule

// File: rtl/xlate_range.sv
// Splits a bus address into aperture fields and checks it against the
// current aperture size. Purely combinational.
// Assumes APER_BASE is aligned to 2**APER_LOG2.
module xlate_range
    import aperture_xlate_pkg::*;
#(
    parameter logic [31:0] APER_BASE = 32'hC000_0000,
    parameter int          APER_LOG2 = 28,
    parameter int          DIR_IW    = APER_LOG2 - DIR_SHIFT,
    parameter int          APN_W     = APER_LOG2 - PAGE_SHIFT
) (
    input  logic [31:0]       addr,
    input  logic [1:0]        size_shift,
    output logic              in_range,
    output logic [DIR_IW-1:0] dir_idx,
    output logic [L2_IW-1:0]  l2_idx,
    output logic [APN_W-1:0]  apn
);
    logic [31:0] off;
    logic [32:0] limit;

    // Offset from the base and the byte size of the selected aperture
    always_comb begin
        off      = addr - APER_BASE;
        limit    = 33'd1 << (APER_LOG2 - int'(size_shift));
        in_range = (addr >= APER_BASE) && ({1'b0, off} < limit);
    end

    assign dir_idx = off[APER_LOG2-1:DIR_SHIFT];
    assign l2_idx  = off[DIR_SHIFT-1:PAGE_SHIFT];
    assign apn     = off[APER_LOG2-1:PAGE_SHIFT];
endmodule

// File: rtl/xlate_tcache.sv
// Small fully associative translation cache with round-robin fill.
// Assumes the caller fills only on a miss, so tags stay unique.
// A flush clears the valid bits and leaves the fill pointer alone.
module xlate_tcache #(
    parameter int WAYS   = 4,
    parameter int TAG_W  = 16,
    parameter int DATA_W = 20,
    parameter int PTR_W  = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic [TAG_W-1:0]  lookup_tag,
    output logic              hit,
    output logic [DATA_W-1:0] hit_data,
    input  logic              fill_en,
    input  logic [TAG_W-1:0]  fill_tag,
    input  logic [DATA_W-1:0] fill_data
);
    logic [WAYS-1:0]   valid_q;
    logic [WAYS-1:0]   hit_vec;
    logic [TAG_W-1:0]  tag_q  [WAYS];
    logic [DATA_W-1:0] data_q [WAYS];
    logic [PTR_W-1:0]  ptr_q;

    for (genvar g = 0; g < WAYS; g++) begin : g_way
        assign hit_vec[g] = valid_q[g] && (tag_q[g] == lookup_tag);
    end

    // Merge the data of the matching way
    always_comb begin
        hit_data = '0;
        for (int i = 0; i < WAYS; i++)
            if (hit_vec[i]) hit_data = hit_data | data_q[i];
    end
    assign hit = |hit_vec;

    // Valid bits and the rotating fill pointer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
            ptr_q   <= '0;
        end else if (flush) begin
            valid_q <= '0;
        end else if (fill_en) begin
            valid_q[ptr_q] <= 1'b1;
            ptr_q <= (ptr_q == PTR_W'(WAYS - 1)) ? '0 : ptr_q + 1'b1;
        end
    end

    // Tag and data payload of the way being filled
    always_ff @(posedge clk) begin
        if (fill_en && !flush) begin
            tag_q[ptr_q]  <= fill_tag;
            data_q[ptr_q] <= fill_data;
        end
    end

    // R7
    hit_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_vec));
    // R8
    flush_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (valid_q == '0));
endmodule

// File: rtl/aperture_xlate.sv
// Two-level aperture translator top. It takes one request at a time,
// checks range and directory, looks in the cache and fetches the
// second-level entry on a miss. Assumes the memory answers each read
// exactly once.
module aperture_xlate
    import aperture_xlate_pkg::*;
#(
    parameter logic [31:0] APER_BASE  = 32'hC000_0000,
    parameter int          APER_LOG2  = 28,
    parameter int          CACHE_WAYS = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_we,
    input  logic [1:0]  cfg_sel,
    input  logic [31:0] cfg_wdata,
    input  logic        req_valid,
    output logic        req_ready,
    input  logic [31:0] req_addr,
    output logic        rsp_valid,
    output logic        rsp_fault,
    output logic [31:0] rsp_paddr,
    output logic        mem_rd_en,
    output logic [31:0] mem_rd_addr,
    input  logic        mem_rd_valid,
    input  logic [31:0] mem_rd_data
);
    localparam int DIR_IW      = APER_LOG2 - DIR_SHIFT;
    localparam int DIR_ENTRIES = 1 << DIR_IW;
    localparam int APN_W       = APER_LOG2 - PAGE_SHIFT;

    xl_state_e          state_q;
    logic [31:0]        addr_q;
    logic               in_range, dir_present, xl_en, flush, hit, fill_en;
    logic [DIR_IW-1:0]  dir_idx;
    logic [L2_IW-1:0]   l2_idx;
    logic [APN_W-1:0]   apn;
    logic [PPN_W-1:0]   dir_ppn, hit_ppn;
    logic [1:0]         size_shift;
    logic               unused_rd;

    assign unused_rd = ^mem_rd_data[PAGE_SHIFT-1:1];

    xlate_cfg_regs #(.DIR_ENTRIES(DIR_ENTRIES), .DIR_IW(DIR_IW)) u_cfg (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .dir_idx(dir_idx), .dir_present(dir_present),
        .dir_ppn(dir_ppn), .size_shift(size_shift), .xl_en(xl_en), .flush(flush)
    );

    xlate_range #(.APER_BASE(APER_BASE), .APER_LOG2(APER_LOG2),
                  .DIR_IW(DIR_IW), .APN_W(APN_W)) u_range (
        .addr(addr_q), .size_shift(size_shift), .in_range(in_range),
        .dir_idx(dir_idx), .l2_idx(l2_idx), .apn(apn)
    );

    assign fill_en = (state_q == ST_WAIT) && mem_rd_valid && mem_rd_data[0];

    xlate_tcache #(.WAYS(CACHE_WAYS), .TAG_W(APN_W), .DATA_W(PPN_W)) u_cache (
        .clk(clk), .rst_n(rst_n), .flush(flush), .lookup_tag(apn),
        .hit(hit), .hit_data(hit_ppn), .fill_en(fill_en),
        .fill_tag(apn), .fill_data(mem_rd_data[31:PAGE_SHIFT])
    );

    assign req_ready = (state_q == ST_IDLE) && xl_en;

    // Request sequencer: accept, decide, fetch, respond
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            addr_q      <= '0;
            rsp_valid   <= 1'b0;
            rsp_fault   <= 1'b0;
            rsp_paddr   <= '0;
            mem_rd_en   <= 1'b0;
            mem_rd_addr <= '0;
        end else begin
            rsp_valid <= 1'b0;
            mem_rd_en <= 1'b0;
            case (state_q)
                ST_IDLE: if (req_valid && req_ready) begin
                    addr_q  <= req_addr;
                    state_q <= ST_CHECK;
                end
                ST_CHECK: begin
                    if (!in_range || !dir_present) begin
                        rsp_valid <= 1'b1;
                        rsp_fault <= 1'b1;
                        rsp_paddr <= '0;
                        state_q   <= ST_IDLE;
                    end else if (hit) begin
                        rsp_valid <= 1'b1;
                        rsp_fault <= 1'b0;
                        rsp_paddr <= {hit_ppn, addr_q[PAGE_SHIFT-1:0]};
                        state_q   <= ST_IDLE;
                    end else begin
                        mem_rd_en   <= 1'b1;
                        mem_rd_addr <= {dir_ppn, l2_idx, 2'b00};
                        state_q     <= ST_WAIT;
                    end
                end
                ST_WAIT: if (mem_rd_valid) begin
                    rsp_valid <= 1'b1;
                    rsp_fault <= !mem_rd_data[0];
                    rsp_paddr <= mem_rd_data[0] ?
                                 {mem_rd_data[31:PAGE_SHIFT], addr_q[PAGE_SHIFT-1:0]} : '0;
                    state_q   <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // R8
    stall_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !xl_en |-> !req_ready);
    // R4
    single_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |=> !mem_rd_en);
    // R6
    range_noread_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CHECK && !in_range) |=> !mem_rd_en);
    // R9
    rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);
    // R9
    no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(rsp_valid && mem_rd_en));
    // R5
    fault_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault) |-> (rsp_paddr == '0));
endmodule

// File: tb/aperture_xlate_bench.sv
module aperture_xlate_bench;
    localparam logic [31:0] BASE = 32'hC000_0000;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_we;
    logic [1:0]  cfg_sel;
    logic [31:0] cfg_wdata;
    logic        req_valid;
    logic        req_ready;
    logic [31:0] req_addr;
    logic        rsp_valid, rsp_fault;
    logic [31:0] rsp_paddr;
    logic        mem_rd_en;
    logic [31:0] mem_rd_addr;
    logic        mem_rd_valid;
    logic [31:0] mem_rd_data;

    always #10 clk = ~clk;

    aperture_xlate u_aperture_xlate (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .rsp_valid(rsp_valid), .rsp_fault(rsp_fault),
        .rsp_paddr(rsp_paddr), .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr),
        .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;
    int rd_count = 0;
    logic [31:0] last_rd_addr = '0;

    // behavioural reference state
    logic [31:0] mem_img [logic [31:0]];
    bit          m_present [64];
    logic [19:0] m_dir [64];
    logic [2:0]  m_size = '0;
    bit          m_en = 1'b1;
    bit          c_val [4];
    int unsigned c_tag [4];
    logic [19:0] c_ppn [4];
    int          c_ptr = 0;

    task automatic chk(input bit ok, input string rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    // memory: answers each read in the following cycle
    initial begin
        mem_rd_valid = 1'b0;
        mem_rd_data  = '0;
        forever begin
            @(negedge clk);
            mem_rd_valid = 1'b0;
            if (rst_n === 1'b1 && mem_rd_en) begin
                rd_count++;
                last_rd_addr = mem_rd_addr;
                mem_rd_valid = 1'b1;
                mem_rd_data  = mem_img.exists(mem_rd_addr) ? mem_img[mem_rd_addr] : 32'h0;
            end
        end
    end

    // per-cycle comparison against the reference
    initial begin
        forever begin
            @(posedge clk);
            #5;
            if (rst_n === 1'b1) begin
                if (!m_en) chk(!req_ready, "R8", "ready while disabled", {31'b0, req_ready}, 0);
                chk(!(rsp_valid && mem_rd_en), "R9", "response with read",
                    {30'b0, rsp_valid, mem_rd_en}, 0);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            summary();
            $finish;
        end
    end

    task automatic cfg_wr(input logic [1:0] sel, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1;
        cfg_sel = sel;
        cfg_wdata = d;
        if (sel == 2'd0) begin
            m_present[d[5:0]] = d[8];
            m_dir[d[5:0]] = d[31:12];
        end else if (sel == 2'd1) begin
            m_size = d[5:3];
        end else if (sel == 2'd2) begin
            if (d[7] && !m_en) for (int i = 0; i < 4; i++) c_val[i] = 1'b0;
            m_en = d[7];
        end
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic model(input logic [31:0] a, output bit ef, output logic [31:0] epa,
                         output int er, output logic [31:0] eaddr);
        logic [31:0] off;
        longint unsigned lim;
        int d;
        int unsigned apn;
        logic [31:0] ent;
        off = a - BASE;
        lim = 64'd1 << (28 - (int'(m_size[2]) + int'(m_size[1]) + int'(m_size[0])));
        ef = 1'b1; epa = '0; er = 0; eaddr = '0;
        if (a < BASE || longint'(off) >= lim) return;
        d = int'(off >> 22);
        if (!m_present[d]) return;
        apn = off >> 12;
        for (int i = 0; i < 4; i++)
            if (c_val[i] && c_tag[i] == apn) begin
                ef = 1'b0;
                epa = {c_ppn[i], a[11:0]};
                return;
            end
        er = 1;
        eaddr = {m_dir[d], a[21:12], 2'b00};
        ent = mem_img.exists(eaddr) ? mem_img[eaddr] : 32'h0;
        if (ent[0]) begin
            ef = 1'b0;
            epa = {ent[31:12], a[11:0]};
            c_val[c_ptr] = 1'b1;
            c_tag[c_ptr] = apn;
            c_ppn[c_ptr] = ent[31:12];
            c_ptr = (c_ptr + 1) % 4;
        end
    endtask

    task automatic xlate(input logic [31:0] a, input string rq);
        bit ef;
        logic [31:0] epa, eaddr;
        int er, lat, r0;
        @(negedge clk);
        req_valid = 1'b1;
        req_addr = a;
        while (!req_ready) @(negedge clk);
        model(a, ef, epa, er, eaddr);
        r0 = rd_count;
        @(negedge clk);
        req_valid = 1'b0;
        lat = 1;
        while (!rsp_valid && lat < 50) begin
            @(negedge clk);
            lat++;
        end
        chk(rsp_valid, rq, "response seen", {31'b0, rsp_valid}, 1);
        chk(rsp_fault == ef, rq, "fault", {31'b0, rsp_fault}, {31'b0, ef});
        chk(rsp_paddr == epa, rq, "paddr", rsp_paddr, epa);
        chk(rd_count - r0 == er, rq, "read count", rd_count - r0, er);
        if (er == 1) chk(last_rd_addr == eaddr, rq, "read address", last_rd_addr, eaddr);
        chk(lat == ((er == 1) ? 3 : 2), rq, "latency", lat, (er == 1) ? 3 : 2);
        @(negedge clk);
        chk(!rsp_valid, "R9", "pulse width", {31'b0, rsp_valid}, 0);
    endtask

    initial begin
        int r_st;
        rst_n = 1'b0; cfg_we = 1'b0; cfg_sel = '0; cfg_wdata = '0;
        req_valid = 1'b0; req_addr = '0;
        for (int i = 0; i < 64; i++) begin m_present[i] = 1'b0; m_dir[i] = '0; end
        for (int i = 0; i < 4; i++) begin c_val[i] = 1'b0; c_tag[i] = 0; c_ppn[i] = '0; end
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(req_ready, "R1", "ready after reset", {31'b0, req_ready}, 1);
        chk(!rsp_valid, "R1", "no response after reset", {31'b0, rsp_valid}, 0);
        chk(!mem_rd_en, "R1", "no read after reset", {31'b0, mem_rd_en}, 0);
        xlate(BASE + 32'h5123, "R1");

        // R2 directory loads with attribute and reserved bits set
        cfg_wr(2'd0, (32'h00100 << 12) | (32'h5 << 9) | 32'h100 | (32'h3 << 6) | 32'd0);
        cfg_wr(2'd0, (32'h00200 << 12) | 32'h100 | 32'd1);
        cfg_wr(2'd0, (32'h00300 << 12) | (32'h7 << 9) | 32'h100 | 32'd7);
        cfg_wr(2'd0, (32'h00500 << 12) | 32'h100 | 32'd8);
        cfg_wr(2'd0, (32'h00600 << 12) | 32'h100 | 32'd16);
        cfg_wr(2'd0, (32'h00400 << 12) | (32'h2 << 9) | 32'h100 | 32'd63);
        mem_img[32'h0010_0000 + 5 * 4]    = 32'hABCD_E001;
        mem_img[32'h0010_0000 + 6 * 4]    = 32'h1234_5000;
        mem_img[32'h0020_0000]            = 32'h0BEE_F001;
        mem_img[32'h0030_0000 + 1023 * 4] = 32'h7777_7001;
        mem_img[32'h0040_0000 + 1023 * 4] = 32'h6363_6001;
        mem_img[32'h0050_0000]            = 32'h8888_8001;
        mem_img[32'h0060_0000]            = 32'h1616_1001;
        for (int i = 10; i < 15; i++)
            mem_img[32'h0010_0000 + 32'(i) * 4] = ((32'h10000 + 32'(i)) << 12) | 32'h1;

        xlate(BASE + 32'h5123, "R4");             // miss, one read
        xlate(BASE + 32'h5ABC, "R7");             // hit, no read
        xlate(BASE + 32'h6000, "R5");             // entry bit 0 clear
        xlate(BASE + 32'h6004, "R5");             // not cached: read again
        xlate(BASE + (32'd1 << 22) + 32'h42, "R2");
        xlate(BASE + 32'h0FFF_FFFF, "R6");        // last byte of 256 MiB
        xlate(BASE - 32'd4, "R6");                // below base

        // R6 size codes
        cfg_wr(2'd1, 32'd32);
        xlate(BASE + 32'h0FFF_FFFF, "R6");        // cached but now out of range
        cfg_wr(2'd1, 32'd48);
        xlate(BASE + 32'h0400_0000, "R6");
        xlate(BASE + 32'h0200_0010, "R6");
        cfg_wr(2'd1, 32'd56);
        xlate(BASE + 32'h0200_0000, "R6");
        xlate(BASE + 32'h01FF_F7FF, "R6");
        cfg_wr(2'd1, 32'd0);

        // R3 invalidate a cached directory entry
        xlate(BASE + (32'd1 << 22) + 32'h10, "R3");
        cfg_wr(2'd0, 32'd1);
        xlate(BASE + (32'd1 << 22) + 32'h10, "R3");

        // R7 round-robin eviction after a flush
        cfg_wr(2'd2, 32'h2200);
        cfg_wr(2'd2, 32'h2280);
        for (int i = 10; i < 15; i++) xlate(BASE + (32'(i) << 12) + 32'h8, "R7");
        xlate(BASE + (32'd10 << 12), "R7");
        xlate(BASE + (32'd14 << 12) + 32'h1, "R7");

        // R8 stale entry, stall, then flush on re-enable
        mem_img[32'h0010_0000 + 14 * 4] = 32'h5555_5001;
        xlate(BASE + (32'd14 << 12) + 32'h2, "R7");
        cfg_wr(2'd2, 32'h2200);
        r_st = rd_count;
        fork
            xlate(BASE + (32'd14 << 12) + 32'h3, "R8");
            begin
                repeat (6) @(negedge clk);
                chk(rd_count == r_st, "R8", "reads while stalled", rd_count, r_st);
                chk(!rsp_valid, "R8", "response while stalled", {31'b0, rsp_valid}, 0);
                cfg_wr(2'd2, 32'h2280);
            end
        join
        cfg_wr(2'd2, 32'h2280);                  // already enabled: no flush
        xlate(BASE + (32'd14 << 12) + 32'h4, "R8");

        done = 1'b1;
        summary();
        $finish;
    end
endmodule